// File: doc/BRIEF.md
# Fuse PROM Programming Sequencer

This block sits inside a device programmer and burns one 4-bit word into a bipolar fuse PROM per command. A command carries a target address and a data pattern. While the command runs, the block holds the part at its normal supply. It drives the address lines and sets each data line either to a hard pull to ground (the fuse is blown) or to a pull-up (the fuse is kept). It keeps the part's outputs disabled, asks an external regulator for the boosted programming supply, and waits for the regulator to report that supply as stable. It then strobes the output-enable line for one millisecond, releases the strobe, drops the boost request, and waits for a cooling interval before it reports completion.

All intervals are counted in clock cycles. The pulse width comes from a clock-rate parameter given in kHz, so one millisecond is that many cycles. The cooling interval is the number of cycles the boost request was held, multiplied by a ratio parameter, with a minimum floor. If the regulator never reports a stable supply, the sequence skips the pulse, drops the boost, cools, and completes with an error flag raised.

Top module: `fuse_prog_seq`

## Requirements
- R1: After reset the block is idle: busy, done, err, vnom_en, boost_req and prog_oe are all 0.
- R2: A command (cmd_valid high at a clock edge) is taken only when idle and not in the completion cycle. busy goes high in the cycle after acceptance and stays high until cooling ends. A cmd_valid seen while busy starts nothing and does not alter the address or pattern in use.
- R3: While busy, vnom_en is 1. prom_addr and pull_low hold the accepted cmd_addr and cmd_data and do not change. A pull_low bit of 1 pulls that data line to ground so its fuse blows, and a 0 selects the pull-up. Exactly SETUP_CYC+DISABLE_CYC cycles pass between busy rising and boost_req rising.
- R4: prog_oe is 0 in the cycle boost_req rises and in the cycle before it.
- R5: prog_oe rises only after boost_ok has been seen high at a clock edge. It stays high for exactly CLK_KHZ cycles (1 ms), and only while boost_req is 1.
- R6: prog_oe falls exactly GUARD_CYC cycles before boost_req falls.
- R7: The cooling interval, from boost_req falling to done, lasts max(H*COOL_RATIO, COOL_MIN) cycles, where H is the number of cycles boost_req was high.
- R8: If boost_ok is not seen within BOOST_TMO cycles of boost_req rising, no pulse is issued, boost_req is held for GUARD_CYC more cycles, and err is 1 at done. err stays 1 until the next command is accepted, which clears it.
- R9: done is a single-cycle pulse that follows the last cooling cycle. busy, boost_req and prog_oe are all 0 while done is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_addr | input | ADDR_W | Target word address |
| cmd_data | input | DATA_W | Pattern; 1 = blow fuse |
| boost_ok | input | 1 | Boosted supply reported stable |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last sequence timed out waiting for boost |
| prom_addr | output | ADDR_W | Address lines to the PROM |
| pull_low | output | DATA_W | Per data line: 1 = hard pull to ground, 0 = pull-up |
| vnom_en | output | 1 | Hold nominal supply |
| boost_req | output | 1 | Request boosted programming supply |
| prog_oe | output | 1 | Output enable, used as the program strobe |

## Verification
The bench targets the boundary where boost_ok arrives in the very cycle the boost timeout expires. A design that gives the timeout priority there would abort a good supply and report an error. It covers both sides of the cooling floor. A design that ignores the floor, or that counts the boost time one cycle short, produces a cooling interval off by the floor or by the ratio. It holds cmd_valid with a different address in the middle of a run: a block that accepts it would change prom_addr while burning, or start a second run. It also checks that err survives into idle and clears at the next accept.

// File: rtl/fuse_prog_pkg.sv
package fuse_prog_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_SETUP,
      ST_DISABLE,
      ST_BOOST_WAIT,
      ST_PULSE,
      ST_UNBOOST,
      ST_COOL,
      ST_DONE
   } prog_state_e;

   function automatic int pmax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fuse_prog_timer.sv
module fuse_prog_timer #(
   parameter int TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - TW'(1);
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/fuse_prog_cool.sv
module fuse_prog_cool #(
   parameter int BT_W       = 8,
   parameter int CT_W       = 10,
   parameter int COOL_RATIO = 2,
   parameter int COOL_MIN   = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clear,
   input  logic            count_en,
   output logic [CT_W-1:0] cool_cyc
);

   localparam int SH = (COOL_RATIO > 1) ? $clog2(COOL_RATIO) : 0;

   logic [BT_W-1:0] on_q;
   logic [CT_W-1:0] on_total;
   logic [CT_W-1:0] scaled;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         on_q <= '0;
      end else if (clear) begin
         on_q <= '0;
      end else if (count_en) begin
         on_q <= on_q + BT_W'(1);
      end
   end

   // includes the boost cycle in progress when the value is consumed
   assign on_total = CT_W'(on_q) + CT_W'(1);

   generate
      if ((COOL_RATIO & (COOL_RATIO - 1)) == 0) begin : g_shift
         assign scaled = on_total << SH;
      end else begin : g_mul
         assign scaled = on_total * CT_W'(COOL_RATIO);
      end
   endgenerate

   assign cool_cyc = (scaled < CT_W'(COOL_MIN)) ? CT_W'(COOL_MIN) : scaled;

endmodule

// File: rtl/fuse_prog_fsm.sv
module fuse_prog_fsm
   import fuse_prog_pkg::*;
#(
   parameter int TW          = 10,
   parameter int CT_W        = 10,
   parameter int SETUP_CYC   = 3,
   parameter int DISABLE_CYC = 2,
   parameter int BOOST_TMO   = 40,
   parameter int PULSE_CYC   = 64,
   parameter int GUARD_CYC   = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_valid,
   input  logic            boost_ok,
   input  logic [CT_W-1:0] cool_cyc,
   output prog_state_e     state,
   output logic            accept,
   output logic            abort
);

   prog_state_e   st_q, st_d;
   logic          tm_load;
   logic [TW-1:0] tm_val;
   logic          tm_exp;

   fuse_prog_timer #(.TW(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tm_load),
      .load_val (tm_val),
      .expired  (tm_exp)
   );

   always_comb begin
      st_d    = st_q;
      tm_load = 1'b0;
      tm_val  = '0;
      accept  = 1'b0;
      abort   = 1'b0;
      unique case (st_q)
         ST_IDLE: if (cmd_valid) begin
            accept  = 1'b1;
            st_d    = ST_SETUP;
            tm_load = 1'b1;
            tm_val  = TW'(SETUP_CYC - 1);
         end
         ST_SETUP: if (tm_exp) begin
            st_d    = ST_DISABLE;
            tm_load = 1'b1;
            tm_val  = TW'(DISABLE_CYC - 1);
         end
         ST_DISABLE: if (tm_exp) begin
            st_d    = ST_BOOST_WAIT;
            tm_load = 1'b1;
            tm_val  = TW'(BOOST_TMO - 1);
         end
         ST_BOOST_WAIT: if (boost_ok) begin
            st_d    = ST_PULSE;
            tm_load = 1'b1;
            tm_val  = TW'(PULSE_CYC - 1);
         end else if (tm_exp) begin
            abort   = 1'b1;
            st_d    = ST_UNBOOST;
            tm_load = 1'b1;
            tm_val  = TW'(GUARD_CYC - 1);
         end
         ST_PULSE: if (tm_exp) begin
            st_d    = ST_UNBOOST;
            tm_load = 1'b1;
            tm_val  = TW'(GUARD_CYC - 1);
         end
         ST_UNBOOST: if (tm_exp) begin
            st_d    = ST_COOL;
            tm_load = 1'b1;
            tm_val  = TW'(cool_cyc) - TW'(1);
         end
         ST_COOL: if (tm_exp) st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state = st_q;

endmodule

// File: rtl/fuse_prog_seq.sv
module fuse_prog_seq
   import fuse_prog_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int DATA_W      = 4,
   parameter int CLK_KHZ     = 64,
   parameter int SETUP_CYC   = 3,
   parameter int DISABLE_CYC = 2,
   parameter int BOOST_TMO   = 40,
   parameter int GUARD_CYC   = 2,
   parameter int COOL_RATIO  = 2,
   parameter int COOL_MIN    = 150
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_data,
   input  logic              boost_ok,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic [ADDR_W-1:0] prom_addr,
   output logic [DATA_W-1:0] pull_low,
   output logic              vnom_en,
   output logic              boost_req,
   output logic              prog_oe
);

   localparam int PULSE_CYC = CLK_KHZ;
   localparam int BT_W = $clog2(BOOST_TMO + PULSE_CYC + GUARD_CYC + 2);
   localparam int CT_W = pmax(BT_W + $clog2(COOL_RATIO) + 1, $clog2(COOL_MIN + 1));
   localparam int TW   = pmax(CT_W, pmax($clog2(SETUP_CYC + 1), $clog2(DISABLE_CYC + 1)));

   generate
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("fuse_prog_seq: ADDR_W and DATA_W must be at least 1");
      end
      if (SETUP_CYC < 1 || DISABLE_CYC < 1 || GUARD_CYC < 1 || BOOST_TMO < 1) begin : g_bad_time
         $error("fuse_prog_seq: every interval must be at least one cycle");
      end
      if (CLK_KHZ < 1 || COOL_RATIO < 1 || COOL_MIN < 1) begin : g_bad_rate
         $error("fuse_prog_seq: CLK_KHZ, COOL_RATIO and COOL_MIN must be positive");
      end
   endgenerate

   prog_state_e     st;
   logic            accept, abort;
   logic [CT_W-1:0] cool_cyc;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] pat_q;
   logic              err_q;

   fuse_prog_fsm #(
      .TW(TW), .CT_W(CT_W), .SETUP_CYC(SETUP_CYC), .DISABLE_CYC(DISABLE_CYC),
      .BOOST_TMO(BOOST_TMO), .PULSE_CYC(PULSE_CYC), .GUARD_CYC(GUARD_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .boost_ok  (boost_ok),
      .cool_cyc  (cool_cyc),
      .state     (st),
      .accept    (accept),
      .abort     (abort)
   );

   fuse_prog_cool #(
      .BT_W(BT_W), .CT_W(CT_W), .COOL_RATIO(COOL_RATIO), .COOL_MIN(COOL_MIN)
   ) u_cool (
      .clk      (clk),
      .rst_n    (rst_n),
      .clear    (accept),
      .count_en (boost_req),
      .cool_cyc (cool_cyc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
         pat_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         if (accept) begin
            addr_q <= cmd_addr;
            pat_q  <= cmd_data;
            err_q  <= 1'b0;
         end else if (abort) begin
            err_q  <= 1'b1;
         end
      end
   end

   assign busy      = (st != ST_IDLE) && (st != ST_DONE);
   assign done      = (st == ST_DONE);
   assign boost_req = (st == ST_BOOST_WAIT) || (st == ST_PULSE) || (st == ST_UNBOOST);
   assign prog_oe   = (st == ST_PULSE);
   assign vnom_en   = busy;
   assign err       = err_q;
   assign prom_addr = addr_q;
   assign pull_low  = pat_q;

endmodule

// File: rtl/fuse_prog_seq_chk.sv
module fuse_prog_seq_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              boost_ok,
   input logic              busy,
   input logic              done,
   input logic              err,
   input logic [ADDR_W-1:0] prom_addr,
   input logic [DATA_W-1:0] pull_low,
   input logic              vnom_en,
   input logic              boost_req,
   input logic              prog_oe
);

   a_r3_held_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      busy && $past(busy) |-> $stable(prom_addr) && $stable(pull_low));

   a_r3_nominal_under_boost: assert property (@(posedge clk) disable iff (!rst_n)
      boost_req |-> vnom_en);

   a_r4_quiet_at_boost: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(boost_req) |-> !prog_oe && !$past(prog_oe));

   a_r5_strobe_in_boost: assert property (@(posedge clk) disable iff (!rst_n)
      prog_oe |-> boost_req);

   a_r5_strobe_after_ok: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(prog_oe) |-> $past(boost_ok));

   a_r6_strobe_off_first: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(boost_req) |-> !$past(prog_oe));

   a_r8_no_strobe_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      prog_oe |-> !err);

   a_r9_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy && !boost_req && !prog_oe);

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind fuse_prog_seq fuse_prog_seq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .boost_ok  (boost_ok),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .prom_addr (prom_addr),
   .pull_low  (pull_low),
   .vnom_en   (vnom_en),
   .boost_req (boost_req),
   .prog_oe   (prog_oe)
);

// File: tb/tb_fuse_prog_seq.sv
`timescale 1ns/1ps
module tb_fuse_prog_seq;

   localparam int AW = 8, DW = 4, KHZ = 64, SETUP = 3, DIS = 2;
   localparam int TMO = 40, GUARD = 2, RATIO = 2, CMIN = 150;

   logic clk = 1'b0, rst_n = 1'b0, cmd_valid = 1'b0, boost_ok = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_data = '0;
   logic busy, done, err, vnom_en, boost_req, prog_oe;
   logic [AW-1:0] prom_addr;
   logic [DW-1:0] pull_low;

   always #2.5 clk = ~clk;

   fuse_prog_seq #(
      .ADDR_W(AW), .DATA_W(DW), .CLK_KHZ(KHZ), .SETUP_CYC(SETUP), .DISABLE_CYC(DIS),
      .BOOST_TMO(TMO), .GUARD_CYC(GUARD), .COOL_RATIO(RATIO), .COOL_MIN(CMIN)
   ) dut (.*);

   typedef struct {
      logic [AW-1:0] addr;
      logic [DW-1:0] data;
      bit            err;
      int            h;
   } exp_t;

   exp_t q[$];
   int n_chk = 0, n_fail = 0;
   int sup_delay = 1, wcnt = 0;
   bit ended = 0;

   task automatic chk(input string req, input string what, input int act, input int expv);
      n_chk++;
      if (act != expv) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // regulator model: boost_ok after sup_delay cycles of request
   always @(negedge clk) begin
      if (!boost_req) begin
         boost_ok = 1'b0;
         wcnt = 0;
      end else if (!boost_ok) begin
         wcnt++;
         if (wcnt >= sup_delay) boost_ok = 1'b1;
      end
   end

   // monitor / scoreboard
   int sc, h, p, g, c;
   bit seen_boost, seen_oe;
   logic prev_busy = 1'b0;
   logic [AW-1:0] a_at;
   logic [DW-1:0] d_at;

   always @(negedge clk) begin
      if (rst_n) begin
         if (busy && !prev_busy) begin
            sc = 0; h = 0; p = 0; g = 0; c = 0; seen_boost = 0; seen_oe = 0;
            chk("R3", "vnom_en at start", int'(vnom_en), 1);
         end
         if (busy) begin
            if (boost_req) begin
               if (!seen_boost) begin
                  seen_boost = 1;
                  a_at = prom_addr;
                  d_at = pull_low;
                  chk("R4", "prog_oe at boost rise", int'(prog_oe), 0);
                  chk("R3", "cycles busy to boost", sc, SETUP + DIS);
               end
               h++;
               if (prog_oe) begin
                  p++;
                  seen_oe = 1;
               end else if (seen_oe) begin
                  g++;
               end
            end else if (seen_boost) begin
               c++;
            end else begin
               sc++;
            end
         end
         if (done) begin
            chk("R9", "busy during done", int'(busy), 0);
            if (q.size() == 0) begin
               chk("R2", "done without command", 1, 0);
            end else begin
               exp_t e;
               int ce;
               e = q.pop_front();
               ce = (e.h * RATIO < CMIN) ? CMIN : e.h * RATIO;
               chk("R3", "address burned", int'(a_at), int'(e.addr));
               chk("R3", "pull_low pattern", int'(d_at), int'(e.data));
               chk("R8", "err at done", int'(err), int'(e.err));
               chk("R7", "boost cycles", h, e.h);
               chk("R5", "pulse cycles", p, e.err ? 0 : KHZ);
               if (!e.err) chk("R6", "guard cycles", g, GUARD);
               chk("R7", "cool cycles", c, ce);
            end
         end
         prev_busy = busy;
      end
   end

   task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input int delay);
      exp_t e;
      do @(negedge clk); while (busy || done);
      e.addr = a;
      e.data = d;
      e.err  = (delay > TMO);
      e.h    = e.err ? (TMO + GUARD) : (delay + KHZ + GUARD);
      q.push_back(e);
      sup_delay = delay;
      cmd_addr  = a;
      cmd_data  = d;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R2", "busy after accept", int'(busy), 1);
      chk("R8", "err cleared on accept", int'(err), 0);
   endtask

   task automatic wait_empty();
      while (q.size() != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "busy", int'(busy), 0);
      chk("R1", "done", int'(done), 0);
      chk("R1", "err", int'(err), 0);
      chk("R1", "vnom_en", int'(vnom_en), 0);
      chk("R1", "boost_req", int'(boost_req), 0);
      chk("R1", "prog_oe", int'(prog_oe), 0);

      send(8'h00, 4'hF, 1);      // floor applies: 67*2 < 150
      send(8'hA5, 4'h5, 20);     // ratio applies: 86*2
      send(8'hFF, 4'h0, TMO);    // ok arrives on the timeout cycle
      send(8'h3C, 4'hA, 1000);   // never ok: timeout
      wait_empty();
      chk("R8", "err held in idle", int'(err), 1);
      chk("R2", "idle after error", int'(busy), 0);
      send(8'h12, 4'h3, 5);

      // command held while busy must be ignored
      send(8'h77, 4'h9, 10);
      repeat (10) @(negedge clk);
      cmd_addr  = 8'h55;
      cmd_data  = 4'h6;
      cmd_valid = 1'b1;
      repeat (30) @(negedge clk);
      chk("R2", "prom_addr during ignored command", int'(prom_addr), 8'h77);
      cmd_valid = 1'b0;
      wait_empty();
      repeat (5) @(negedge clk);
      chk("R2", "no run from ignored command", int'(busy), 0);
      chk("R2", "prom_addr after ignored command", int'(prom_addr), 8'h77);
      finish_run();
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule